// File: doc/BRIEF.md
# ModR/M Effective Address Generator

This block turns an operand-descriptor byte (ModR/M) into a 32-bit memory address for an instruction-execution pipeline. When the caller pulses `start_i` with the byte, the block splits it into three fields, reads the base register that the low field names, and decides whether a displacement has to follow. Any displacement bytes are pulled one at a time from an instruction byte stream over a valid/ready handshake.

There are three outcomes. A register-indirect address completes one cycle after start. A one-byte displacement is sign-extended and added to the base. A four-byte little-endian displacement is either added to the base or, in the absolute form, used alone as the address. Scaled-index forms and register-direct operands are rejected through a one-cycle `unsupported_o` pulse and do not complete.

The result stays on `ea_o` until the next successful completion. The middle field of the byte stays on `reg_field_o`, so a downstream decoder can use it as a register index or a sub-operation code.

Top module: `modrm_ea_gen`

## Requirements
- R1: The byte is read with mod in bits 7:6, reg in bits 5:3 and rm in bits 2:0. `rf_sel_o` follows rm of `modrm_i`. `reg_field_o` shows reg of the byte accepted at start, starting in the cycle after the start edge.
- R2: With mod 0 and rm not equal to 4 or 5, `ea_o` becomes the register value read during the start cycle. `done_o` pulses in the cycle after start, and no stream byte is accepted.
- R3: With mod 0 and rm 5, the register is not used. Four stream bytes form the address, with the first byte in bits 7:0 and the last in bits 31:24.
- R4: With mod 1, one stream byte is sign-extended and added to the rm register. Base 0x61 with byte 0xFF gives 0x60.
- R5: With mod 2, four stream bytes in little-endian order are added to the rm register. Base 0x61 with FF FF FF FF gives 0x60.
- R6: A byte is accepted only in a cycle where both `byte_valid_i` and `byte_ready_o` are high. `byte_ready_o` is high exactly while the block is collecting, and cycles with valid low only stretch the collection.
- R7: `done_o` is a one-cycle pulse in the cycle after the last byte is accepted, or in the cycle after start when no displacement is needed.
- R8: mod 3, or rm 4 with mod 0, 1 or 2, gives a one-cycle `unsupported_o` pulse in the cycle after start. In that case there is no `done_o`, no byte is accepted and `ea_o` keeps its value.
- R9: The base plus displacement sum wraps modulo 2^32.
- R10: `start_i` is ignored while `busy_o` is high. The operation in progress, and its reg field, complete unchanged.
- R11: After reset, `done_o`, `unsupported_o`, `busy_o` and `byte_ready_o` are low, and `ea_o` and `reg_field_o` are zero.
- R12: `ea_o` holds its value while the block is idle and no start arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin decoding `modrm_i` (accepted when idle) |
| modrm_i | input | 8 | Operand-descriptor byte |
| rf_sel_o | output | 3 | Register-file read index (rm field) |
| rf_data_i | input | 32 | Register-file read data for `rf_sel_o` |
| byte_valid_i | input | 1 | Stream byte available |
| byte_data_i | input | 8 | Stream byte |
| byte_ready_o | output | 1 | Block accepts a stream byte this cycle |
| busy_o | output | 1 | Displacement collection in progress |
| done_o | output | 1 | Address complete pulse |
| unsupported_o | output | 1 | Unsupported addressing form pulse |
| ea_o | output | 32 | Effective address |
| reg_field_o | output | 3 | Bits 5:3 of the accepted byte |

## Verification
Some internal faults show up at the ports at once. A wrong byte count or a lost mode shows up on the very next edge as `done_o` or `byte_ready_o` disagreeing with the reference model, because collection ends early, ends late or never starts. Other faults only show when the operation completes. A fault in byte placement, sign extension or base capture stays hidden until then, and then appears as a wrong `ea_o` in the same cycle as `done_o`. For that reason the known patterns use distinct byte values in every lane, and a negative single byte, so that each of these faults changes the address.

// File: rtl/modrm_ea_pkg.sv
package modrm_ea_pkg;

    typedef enum logic [2:0] {
        AM_REG_IND,
        AM_ABS32,
        AM_BASE_D8,
        AM_BASE_D32,
        AM_REJECT
    } addr_mode_e;

    typedef enum logic {
        ST_IDLE,
        ST_FETCH
    } ea_state_e;

    localparam int unsigned FLD_W      = 3;
    localparam int unsigned BYTE_W     = 8;
    localparam logic [1:0]  MOD_IND    = 2'd0;
    localparam logic [1:0]  MOD_D8     = 2'd1;
    localparam logic [1:0]  MOD_D32    = 2'd2;
    localparam logic [2:0]  RM_INDEXED = 3'd4;
    localparam logic [2:0]  RM_ABS     = 3'd5;

endpackage

// File: rtl/modrm_field_decode.sv
module modrm_field_decode
    import modrm_ea_pkg::*;
#(
    parameter int unsigned DISP_BYTES = 4,
    localparam int unsigned CNT_W = $clog2(DISP_BYTES + 1)
) (
    input  logic [7:0]       modrm_i,
    output addr_mode_e       mode_o,
    output logic [FLD_W-1:0] reg_fld_o,
    output logic [FLD_W-1:0] rm_fld_o,
    output logic [CNT_W-1:0] need_o
);

    logic [1:0] mod_fld;

    assign mod_fld   = modrm_i[7:6];
    assign reg_fld_o = modrm_i[5:3];
    assign rm_fld_o  = modrm_i[2:0];

    always_comb begin
        mode_o = AM_REJECT;
        need_o = '0;
        if (rm_fld_o != RM_INDEXED) begin
            unique case (mod_fld)
                MOD_IND: begin
                    if (rm_fld_o == RM_ABS) begin
                        mode_o = AM_ABS32;
                        need_o = CNT_W'(DISP_BYTES);
                    end else begin
                        mode_o = AM_REG_IND;
                    end
                end
                MOD_D8: begin
                    mode_o = AM_BASE_D8;
                    need_o = CNT_W'(1);
                end
                MOD_D32: begin
                    mode_o = AM_BASE_D32;
                    need_o = CNT_W'(DISP_BYTES);
                end
                default: mode_o = AM_REJECT;
            endcase
        end
    end

    // R8: register-direct operands never get a displacement count
    always_comb begin
        if (mod_fld == 2'd3) begin
            assert_direct_rejected_R8: assert (mode_o == AM_REJECT && need_o == '0);
        end
    end

endmodule

// File: rtl/ea_disp_shift.sv
module ea_disp_shift
    import modrm_ea_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              shift_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [ADDR_W-1:0] shifted_o
);

    logic [ADDR_W-1:0] acc_d, acc_q;

    // Bytes enter at the top: after N shifts the first byte sits lowest.
    assign shifted_o = {byte_i, acc_q[ADDR_W-1:BYTE_W]};

    always_comb begin
        acc_d = acc_q;
        if (clear_i) begin
            acc_d = '0;
        end else if (shift_i) begin
            acc_d = shifted_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assert_acc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_i && !clear_i) |=> $stable(acc_q));

endmodule

// File: rtl/modrm_ea_gen.sv
module modrm_ea_gen
    import modrm_ea_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned NUM_REGS = 8,
    localparam int unsigned RIDX_W     = $clog2(NUM_REGS),
    localparam int unsigned DISP_BYTES = ADDR_W / BYTE_W,
    localparam int unsigned CNT_W      = $clog2(DISP_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [7:0]        modrm_i,
    output logic [RIDX_W-1:0] rf_sel_o,
    input  logic [ADDR_W-1:0] rf_data_i,
    input  logic              byte_valid_i,
    input  logic [7:0]        byte_data_i,
    output logic              byte_ready_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              unsupported_o,
    output logic [ADDR_W-1:0] ea_o,
    output logic [FLD_W-1:0]  reg_field_o
);

    typedef struct packed {
        ea_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  need;
        logic              sx;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] ea;
        logic [FLD_W-1:0]  reg_fld;
        logic              done;
        logic              unsup;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    addr_mode_e        dec_mode;
    logic [FLD_W-1:0]  dec_reg;
    logic [FLD_W-1:0]  dec_rm;
    logic [CNT_W-1:0]  dec_need;
    logic              acc_clear;
    logic              acc_shift;
    logic [ADDR_W-1:0] acc_shifted;
    logic [ADDR_W-1:0] disp_ext;
    logic [CNT_W-1:0]  cnt_inc;
    logic              take_start;
    logic              take_byte;

    modrm_field_decode #(
        .DISP_BYTES (DISP_BYTES)
    ) u_decode (
        .modrm_i   (modrm_i),
        .mode_o    (dec_mode),
        .reg_fld_o (dec_reg),
        .rm_fld_o  (dec_rm),
        .need_o    (dec_need)
    );

    ea_disp_shift #(
        .ADDR_W (ADDR_W)
    ) u_disp (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (acc_clear),
        .shift_i   (acc_shift),
        .byte_i    (byte_data_i),
        .shifted_o (acc_shifted)
    );

    assign rf_sel_o   = RIDX_W'(dec_rm);
    assign take_start = (ctl_q.st == ST_IDLE) && start_i;
    assign take_byte  = (ctl_q.st == ST_FETCH) && byte_valid_i;
    assign cnt_inc    = ctl_q.cnt + CNT_W'(1);

    // A single byte lands in the top lane; pull it down with sign fill.
    assign disp_ext = ctl_q.sx
        ? {{(ADDR_W-BYTE_W){acc_shifted[ADDR_W-1]}}, acc_shifted[ADDR_W-1 -: BYTE_W]}
        : acc_shifted;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.done  = 1'b0;
        ctl_d.unsup = 1'b0;
        acc_clear   = 1'b0;
        acc_shift   = 1'b0;
        if (take_start) begin
            ctl_d.reg_fld = dec_reg;
            ctl_d.cnt     = '0;
            ctl_d.need    = dec_need;
            ctl_d.sx      = (dec_mode == AM_BASE_D8);
            ctl_d.base    = rf_data_i;
            unique case (dec_mode)
                AM_REG_IND: begin
                    ctl_d.ea   = rf_data_i;
                    ctl_d.done = 1'b1;
                end
                AM_ABS32: begin
                    ctl_d.base = '0;
                    ctl_d.st   = ST_FETCH;
                    acc_clear  = 1'b1;
                end
                AM_BASE_D8, AM_BASE_D32: begin
                    ctl_d.st  = ST_FETCH;
                    acc_clear = 1'b1;
                end
                default: ctl_d.unsup = 1'b1;
            endcase
        end else if (take_byte) begin
            acc_shift = 1'b1;
            ctl_d.cnt = cnt_inc;
            if (cnt_inc == ctl_q.need) begin
                ctl_d.ea   = ctl_q.base + disp_ext;
                ctl_d.done = 1'b1;
                ctl_d.st   = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, cnt: '0, need: '0, sx: 1'b0, base: '0,
                       ea: '0, reg_fld: '0, done: 1'b0, unsup: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_o        = (ctl_q.st == ST_FETCH);
    assign byte_ready_o  = (ctl_q.st == ST_FETCH);
    assign done_o        = ctl_q.done;
    assign unsupported_o = ctl_q.unsup;
    assign ea_o          = ctl_q.ea;
    assign reg_field_o   = ctl_q.reg_fld;

    assert_pulse_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && unsupported_o));

    assert_unsup_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        unsupported_o |-> $past(start_i && !busy_o));

    assert_done_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(start_i && !busy_o) || $past(byte_valid_i && byte_ready_o)));

    assert_ea_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(ea_o));

    assert_busy_ignores_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !byte_valid_i) |=> (busy_o && $stable(reg_field_o)));

    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (ctl_q.cnt < ctl_q.need));

endmodule

// File: tb/modrm_ea_gen_test.sv
module modrm_ea_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  modrm_i = 8'h00;
    logic [2:0]  rf_sel_o;
    logic [31:0] rf_data_i;
    logic        byte_valid_i = 1'b0;
    logic [7:0]  byte_data_i = 8'h00;
    logic        byte_ready_o, busy_o, done_o, unsupported_o;
    logic [31:0] ea_o;
    logic [2:0]  reg_field_o;

    logic [31:0] regs [8];
    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    assign rf_data_i = regs[rf_sel_o];

    modrm_ea_gen uut (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .modrm_i (modrm_i),
        .rf_sel_o (rf_sel_o), .rf_data_i (rf_data_i),
        .byte_valid_i (byte_valid_i), .byte_data_i (byte_data_i),
        .byte_ready_o (byte_ready_o), .busy_o (busy_o), .done_o (done_o),
        .unsupported_o (unsupported_o), .ea_o (ea_o), .reg_field_o (reg_field_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on each rising edge
    bit          m_busy, m_done, m_unsup, m_sx;
    int          m_need;
    logic [31:0] m_base, m_ea, disp;
    logic [2:0]  m_reg;
    logic [7:0]  m_q [$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_unsup = 0; m_ea = 0; m_reg = 0; m_q.delete();
        end else begin
            m_done = 0; m_unsup = 0;
            if (!m_busy && start_i) begin
                m_reg = modrm_i[5:3];
                if (modrm_i[7:6] == 2'd3 || modrm_i[2:0] == 3'd4) m_unsup = 1;
                else if (modrm_i[7:6] == 2'd0 && modrm_i[2:0] != 3'd5) begin
                    m_ea = regs[modrm_i[2:0]]; m_done = 1;
                end else begin
                    m_busy = 1; m_q.delete();
                    m_sx = (modrm_i[7:6] == 2'd1);
                    m_need = m_sx ? 1 : 4;
                    m_base = (modrm_i[7:6] == 2'd0) ? 32'h0 : regs[modrm_i[2:0]];
                end
            end else if (m_busy && byte_valid_i) begin
                m_q.push_back(byte_data_i);
                if (m_q.size() == m_need) begin
                    if (m_sx) disp = {{24{m_q[0][7]}}, m_q[0]};
                    else disp = {m_q[3], m_q[2], m_q[1], m_q[0]};
                    m_ea = m_base + disp; m_done = 1; m_busy = 0;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R7 done", {31'b0, done_o}, {31'b0, m_done});
            chk("R8 unsupported", {31'b0, unsupported_o}, {31'b0, m_unsup});
            chk("R6 byte_ready", {31'b0, byte_ready_o}, {31'b0, m_busy});
            chk("R10 busy", {31'b0, busy_o}, {31'b0, m_busy});
            chk("R12 ea", ea_o, m_ea);
            chk("R1 reg_field", {29'b0, reg_field_o}, {29'b0, m_reg});
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<=50000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic do_start(input logic [7:0] m);
        @(negedge clk);
        start_i = 1'b1; modrm_i = m;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Hold a byte until accepted; returns at the negedge after the handshake.
    task automatic send(input logic [7:0] b, input int gap);
        for (int i = 0; i < gap; i++) @(negedge clk);
        byte_valid_i = 1'b1; byte_data_i = b;
        while (!byte_ready_o) @(negedge clk);
        @(negedge clk);
        byte_valid_i = 1'b0;
    endtask

    logic [31:0] keep;

    initial begin
        regs[0] = 32'h0000_0061; regs[1] = 32'h0000_005e; regs[2] = 32'hFFFF_FFF0;
        regs[3] = 32'h0000_0010; regs[4] = 32'h0BAD_0004; regs[5] = 32'hDEAD_0000;
        regs[6] = 32'h1234_5678; regs[7] = 32'h0000_0007;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 done", {31'b0, done_o}, 32'h0);
        chk("R11 unsupported", {31'b0, unsupported_o}, 32'h0);
        chk("R11 busy", {31'b0, busy_o}, 32'h0);
        chk("R11 ea", ea_o, 32'h0);
        chk("R11 reg_field", {29'b0, reg_field_o}, 32'h0);
        rst_n = 1'b1;

        // R2, R1: mod 0 rm 6 reg 3
        do_start(8'h1E);
        chk("R2 done", {31'b0, done_o}, 32'h1);
        chk("R2 ea", ea_o, 32'h1234_5678);
        chk("R1 reg_field", {29'b0, reg_field_o}, 32'h3);
        chk("R2 no ready", {31'b0, byte_ready_o}, 32'h0);

        // R3: absolute address, register 5 unused
        do_start(8'h05);
        send(8'h78, 0); send(8'h56, 0); send(8'h34, 0); send(8'h12, 0);
        chk("R3 done", {31'b0, done_o}, 32'h1);
        chk("R3 ea", ea_o, 32'h1234_5678);
        do_start(8'h2D);
        send(8'h60, 1); send(8'h00, 0); send(8'h00, 2); send(8'h00, 0);
        chk("R3 ea small", ea_o, 32'h0000_0060);

        // R4: one-byte displacement, negative and positive
        do_start(8'h50);
        send(8'hFF, 0);
        chk("R4 done", {31'b0, done_o}, 32'h1);
        chk("R4 ea neg", ea_o, 32'h0000_0060);
        do_start(8'h41);
        send(8'h02, 3);
        chk("R4 ea pos", ea_o, 32'h0000_0060);

        // R5, R6: four-byte displacement with stalls
        do_start(8'h80);
        send(8'hFF, 2); send(8'hFF, 0); send(8'hFF, 4); send(8'hFF, 1);
        chk("R5 done", {31'b0, done_o}, 32'h1);
        chk("R5 ea", ea_o, 32'h0000_0060);

        // R9: wrap
        do_start(8'h82);
        send(8'h20, 0); send(8'h00, 0); send(8'h00, 0); send(8'h00, 0);
        chk("R9 wrap", ea_o, 32'h0000_0010);

        // R8: rejected forms leave ea untouched
        keep = ea_o;
        do_start(8'hC0);
        chk("R8 mod3 flag", {31'b0, unsupported_o}, 32'h1);
        chk("R8 mod3 no done", {31'b0, done_o}, 32'h0);
        do_start(8'h04);
        chk("R8 rm4 mod0 flag", {31'b0, unsupported_o}, 32'h1);
        do_start(8'h44);
        chk("R8 rm4 mod1 flag", {31'b0, unsupported_o}, 32'h1);
        do_start(8'h84);
        chk("R8 rm4 mod2 flag", {31'b0, unsupported_o}, 32'h1);
        chk("R8 busy", {31'b0, busy_o}, 32'h0);
        chk("R8 ea kept", ea_o, keep);

        // R10: start during collection ignored
        do_start(8'h90);
        send(8'h10, 0); send(8'h00, 0);
        do_start(8'h1E);
        chk("R10 still busy", {31'b0, busy_o}, 32'h1);
        send(8'h00, 0); send(8'h00, 0);
        chk("R10 ea", ea_o, 32'h0000_0071);
        chk("R10 reg_field", {29'b0, reg_field_o}, 32'h2);

        // R12: idle hold
        repeat (5) @(negedge clk);
        chk("R12 hold", ea_o, 32'h0000_0071);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule